// File: doc/BRIEF.md
# CPU Interrupt and Reset Entry Sequencer

This block takes over the bus of an 8-bit CPU core whenever control has to leave the normal instruction stream. Four sources can cause this: a level-sensitive maskable request, an edge-triggered non-maskable request, an external reset, and the power-on condition that follows the block's own reset. The core signals each instruction boundary, and the sequencer polls its pending requests there. If one is accepted, it runs the entry sequence one bus access per cycle: two discarded reads at the current program counter, three stack-page accesses, and two vector fetches. It then hands the new program counter, stack pointer and status byte back to the core.

The core also hands over three special instructions. The first is the software break, which skips the discarded reads and returns through the maskable vector. The second is wait-for-interrupt, which parks the sequencer until any accepted request appears. The third is stop, which only a reset or power-on request ends. The stack is descending and lives in page 1. Pushes write at the current stack pointer and then decrement it. A reset entry walks the same three stack addresses with reads only.

Status bit layout used throughout: bit 2 is interrupt-disable (I), bit 3 is decimal (D), bit 4 is break (B).

Top module: `irq_entry_seq`

## Requirements
- R1: At an instruction boundary, the maskable request is accepted only when status bit 2 (I) is 0. Priority is reset or power-on first, then the non-maskable request, then the maskable request. Neither reset nor the non-maskable request is ever masked.
- R2: A hardware entry (maskable, non-maskable, reset or power-on) begins one cycle after acceptance with two read cycles whose address is the captured program counter.
- R3: On a maskable or non-maskable entry, three writes follow to address 0x0100+SP, then 0x0100+SP-1, then 0x0100+SP-2. The data written is, in that order, PC[15:8], PC[7:0], and the captured status with bit 4 cleared. The returned stack pointer is SP-3.
- R4: A break command accepted while idle skips the discarded reads. It pushes PC+1 (high byte, then low byte), then the status with bit 4 set, and it vectors through 0xFFFE/0xFFFF.
- R5: The vector pairs are 0xFFFA/0xFFFB for the non-maskable request, 0xFFFC/0xFFFD for reset and power-on, and 0xFFFE/0xFFFF for the maskable request and break. The low byte is read first. The returned PC is {byte read at the high address, byte read at the low address}.
- R6: A reset or power-on entry performs three reads, with no write, at 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, and returns SP-3.
- R7: The completion flag pulses for exactly one cycle after the last vector read. The returned status has bit 2 set, and with the CMOS option (the default) also has bit 3 cleared. All other bits are as captured.
- R8: A falling edge on the active-low non-maskable input latches a request that stays pending until that request is taken. An edge in the same cycle as the take is not lost. The power-on request is pending after the block's reset and is cleared when a reset entry is taken.
- R9: In the wait state, any accepted request starts its entry sequence. In the stop state, only reset or power-on starts an entry; maskable and non-maskable requests leave it stopped and silent on the bus.
- R10: After reset the block is idle: no bus read or write, no completion pulse, not waiting, not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset; arms the power-on request |
| atBoundary | input | 1 | Core is at an instruction boundary (poll point) |
| brkCmd | input | 1 | Core decoded a software break |
| waiCmd | input | 1 | Core decoded wait-for-interrupt |
| stpCmd | input | 1 | Core decoded stop |
| irqReq | input | 1 | Maskable request, level, active high |
| nmiN | input | 1 | Non-maskable request, active low, falling-edge triggered |
| rstReq | input | 1 | External reset request, level |
| statusIn | input | 8 | Core status byte |
| pcIn | input | 16 | Core program counter |
| spIn | input | 8 | Core stack pointer |
| busAddr | output | 16 | Bus address |
| busRead | output | 1 | Read cycle |
| busWrite | output | 1 | Write cycle |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid in the same cycle |
| active | output | 1 | Entry sequence owns the bus |
| waiting | output | 1 | In wait-for-interrupt state |
| stopped | output | 1 | In stop state |
| entryDone | output | 1 | One-cycle completion pulse |
| newPc | output | 16 | Vector target, valid with entryDone |
| newSp | output | 8 | Updated stack pointer, valid with entryDone |
| newStatus | output | 8 | Updated status, valid with entryDone |

## Verification
Two functions can fall on the same clock edge: taking a pending non-maskable request, which clears it, and a fresh falling edge on the non-maskable input, which sets it. The bench drives the falling edge in the very cycle the boundary accepts the pending request. It then checks that a second non-maskable entry follows at the next boundary, and that a third boundary finds nothing pending. The reset-over-NMI case also meets in one cycle, and it is judged the same way: the reset vector is taken first, and the non-maskable entry follows afterwards.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DUM1, ST_DUM2, ST_STK1, ST_STK2, ST_STK3,
    ST_VECL, ST_VECH, ST_WAIT, ST_STOP
  } seqState_e;

  typedef enum logic [1:0] {K_IRQ, K_NMI, K_RST, K_BRK} entryKind_e;
  typedef enum logic [1:0] {A_PC, A_STACK, A_VECLO, A_VECHI} addrSel_e;
  typedef enum logic [1:0] {D_PCHI, D_PCLO, D_STATUS} dataSel_e;

  typedef struct packed {
    logic     capture;
    logic     brkBump;
    addrSel_e addrSel;
    dataSel_e dataSel;
    logic     rd;
    logic     wr;
    logic     decSp;
    logic     takeLo;
    logic     takeHi;
    logic     setBrk;
  } dpCtrl_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       atBoundary,
  input  logic       brkCmd,
  input  logic       waiCmd,
  input  logic       stpCmd,
  input  logic       irqReq,
  input  logic       nmiN,
  input  logic       rstReq,
  input  logic       flagI,
  output dpCtrl_t    ctl,
  output entryKind_e kind,
  output logic       active,
  output logic       waiting,
  output logic       stopped,
  output logic       entryDone
);
  seqState_e  state, nextState;
  entryKind_e kindReg, nextKind, pickKind;
  logic nmiPrev, nmiPend, pwrPend, doneReg, doneNext;
  logic pendRst, pendIrq, anyPend, takeNow, nmiEdge;

  assign pendRst  = rstReq | pwrPend;
  assign pendIrq  = irqReq & ~flagI;
  assign anyPend  = pendRst | nmiPend | pendIrq;
  assign pickKind = pendRst ? K_RST : (nmiPend ? K_NMI : K_IRQ);
  assign nmiEdge  = nmiPrev & ~nmiN;

  always_comb begin
    nextState = state;
    nextKind  = kindReg;
    takeNow   = 1'b0;
    doneNext  = 1'b0;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (brkCmd) begin
          nextState = ST_STK1; nextKind = K_BRK;
          ctl.capture = 1'b1; ctl.brkBump = 1'b1;
        end else if (atBoundary && anyPend) begin
          nextState = ST_DUM1; nextKind = pickKind;
          ctl.capture = 1'b1; takeNow = 1'b1;
        end else if (waiCmd) nextState = ST_WAIT;
        else if (stpCmd) nextState = ST_STOP;
      end
      ST_WAIT: if (anyPend) begin
        nextState = ST_DUM1; nextKind = pickKind;
        ctl.capture = 1'b1; takeNow = 1'b1;
      end
      ST_STOP: if (pendRst) begin
        nextState = ST_DUM1; nextKind = K_RST;
        ctl.capture = 1'b1; takeNow = 1'b1;
      end
      ST_DUM1: begin ctl.rd = 1'b1; ctl.addrSel = A_PC; nextState = ST_DUM2; end
      ST_DUM2: begin ctl.rd = 1'b1; ctl.addrSel = A_PC; nextState = ST_STK1; end
      ST_STK1, ST_STK2, ST_STK3: begin
        ctl.addrSel = A_STACK;
        ctl.decSp   = 1'b1;
        ctl.wr      = (kindReg != K_RST);
        ctl.rd      = (kindReg == K_RST);
        ctl.setBrk  = (kindReg == K_BRK);
        ctl.dataSel = (state == ST_STK1) ? D_PCHI : ((state == ST_STK2) ? D_PCLO : D_STATUS);
        nextState   = (state == ST_STK1) ? ST_STK2 : ((state == ST_STK2) ? ST_STK3 : ST_VECL);
      end
      ST_VECL: begin ctl.rd = 1'b1; ctl.addrSel = A_VECLO; ctl.takeLo = 1'b1; nextState = ST_VECH; end
      ST_VECH: begin
        ctl.rd = 1'b1; ctl.addrSel = A_VECHI; ctl.takeHi = 1'b1;
        nextState = ST_IDLE; doneNext = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= K_IRQ;
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
      pwrPend <= 1'b1;
      doneReg <= 1'b0;
    end else begin
      state   <= nextState;
      kindReg <= nextKind;
      nmiPrev <= nmiN;
      doneReg <= doneNext;
      if (nmiEdge) nmiPend <= 1'b1;
      else if (takeNow && nextKind == K_NMI) nmiPend <= 1'b0;
      if (takeNow && nextKind == K_RST) pwrPend <= 1'b0;
    end
  end

  assign kind      = kindReg;
  assign active    = (state != ST_IDLE) && (state != ST_WAIT) && (state != ST_STOP);
  assign waiting   = (state == ST_WAIT);
  assign stopped   = (state == ST_STOP);
  assign entryDone = doneReg;

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiN) |=> nmiPend); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |=> !doneReg); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !rstReq && !pwrPend) |=> (state == ST_STOP)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && atBoundary && !brkCmd && !waiCmd && !stpCmd && flagI &&
     !rstReq && !pwrPend && !nmiPend) |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter int          I_BIT      = 2,
  parameter int          D_BIT      = 3,
  parameter int          B_BIT      = 4,
  parameter bit          CMOS       = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  entryKind_e        kind,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              entryDone,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [ADDR_W-1:0] newPc,
  output logic [DATA_W-1:0] newSp,
  output logic [DATA_W-1:0] newStatus
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] pcReg, vecBase;
  logic [DATA_W-1:0] spReg, stReg, loReg, pushSt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= '0; spReg <= '0; stReg <= '0; loReg <= '0;
    end else begin
      if (ctl.capture) begin
        pcReg <= ctl.brkBump ? pcIn + ADDR_W'(1) : pcIn;
        spReg <= spIn;
        stReg <= statusIn;
      end
      if (ctl.decSp)  spReg <= spReg - DATA_W'(1);
      if (ctl.takeLo) loReg <= busRdata;
      if (ctl.takeHi) pcReg <= {busRdata, loReg};
    end
  end

  always_comb begin
    case (kind)
      K_NMI:   vecBase = VEC_NMI;
      K_RST:   vecBase = VEC_RST;
      default: vecBase = VEC_IRQ;
    endcase
    case (ctl.addrSel)
      A_PC:    busAddr = pcReg;
      A_STACK: busAddr = {STACK_PAGE, spReg};
      A_VECLO: busAddr = vecBase;
      default: busAddr = vecBase + ADDR_W'(1);
    endcase
    pushSt        = stReg;
    pushSt[B_BIT] = ctl.setBrk;
    case (ctl.dataSel)
      D_PCHI:  busWdata = pcReg[ADDR_W-1:HALF];
      D_PCLO:  busWdata = pcReg[HALF-1:0];
      default: busWdata = pushSt;
    endcase
    newStatus        = stReg;
    newStatus[I_BIT] = 1'b1;
    if (CMOS) newStatus[D_BIT] = 1'b0;
  end

  assign newPc = pcReg;
  assign newSp = spReg;

  AST_WRITE_STACK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> (busAddr[ADDR_W-1:HALF] == STACK_PAGE)); // R3
  AST_DONE_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> newStatus[I_BIT]); // R7
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter bit CMOS = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        atBoundary,
  input  logic        brkCmd,
  input  logic        waiCmd,
  input  logic        stpCmd,
  input  logic        irqReq,
  input  logic        nmiN,
  input  logic        rstReq,
  input  logic [7:0]  statusIn,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  output logic [15:0] busAddr,
  output logic        busRead,
  output logic        busWrite,
  output logic [7:0]  busWdata,
  input  logic [7:0]  busRdata,
  output logic        active,
  output logic        waiting,
  output logic        stopped,
  output logic        entryDone,
  output logic [15:0] newPc,
  output logic [7:0]  newSp,
  output logic [7:0]  newStatus
);
  dpCtrl_t    ctl;
  entryKind_e kind;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .brkCmd(brkCmd),
    .waiCmd(waiCmd), .stpCmd(stpCmd), .irqReq(irqReq), .nmiN(nmiN),
    .rstReq(rstReq), .flagI(statusIn[2]), .ctl(ctl), .kind(kind),
    .active(active), .waiting(waiting), .stopped(stopped), .entryDone(entryDone)
  );

  irq_entry_dp #(.CMOS(CMOS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .kind(kind), .pcIn(pcIn), .spIn(spIn),
    .statusIn(statusIn), .busRdata(busRdata), .entryDone(entryDone),
    .busAddr(busAddr), .busWdata(busWdata), .newPc(newPc), .newSp(newSp),
    .newStatus(newStatus)
  );

  assign busRead  = ctl.rd;
  assign busWrite = ctl.wr;
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int KIRQ = 0, KNMI = 1, KRST = 2, KBRK = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic atBoundary = 0, brkCmd = 0, waiCmd = 0, stpCmd = 0;
  logic irqReq = 0, nmiN = 1, rstReq = 0;
  logic [7:0] statusIn = 8'h00, spIn = 8'hFF;
  logic [15:0] pcIn = 16'h1234;
  logic [15:0] busAddr, newPc;
  logic busRead, busWrite, active, waiting, stopped, entryDone;
  logic [7:0] busWdata, busRdata, newSp, newStatus;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  assign busRdata = memByte(busAddr);

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .brkCmd(brkCmd),
    .waiCmd(waiCmd), .stpCmd(stpCmd), .irqReq(irqReq), .nmiN(nmiN),
    .rstReq(rstReq), .statusIn(statusIn), .pcIn(pcIn), .spIn(spIn),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .active(active),
    .waiting(waiting), .stopped(stopped), .entryDone(entryDone),
    .newPc(newPc), .newSp(newSp), .newStatus(newStatus)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vecOf(input int k);
    return (k == KNMI) ? 16'hFFFA : ((k == KRST) ? 16'hFFFC : 16'hFFFE);
  endfunction

  // expected {addr, rd, wr, wdata} for bus step i (0..6)
  function automatic logic [26:0] expStep(input int k, input int i, input logic [15:0] pc,
                                          input logic [7:0] sp, input logic [7:0] st);
    logic [7:0] d;
    if (i < 2) return {pc, 1'b1, 1'b0, 8'h00};
    if (i < 5) begin
      if (k == KRST) return {8'h01, 8'(sp - 8'(i - 2)), 1'b1, 1'b0, 8'h00};
      d = (i == 2) ? pc[15:8] : ((i == 3) ? pc[7:0] : ((k == KBRK) ? (st | 8'h10) : (st & 8'hEF)));
      return {8'h01, 8'(sp - 8'(i - 2)), 1'b0, 1'b1, d};
    end
    if (i == 5) return {vecOf(k), 1'b1, 1'b0, 8'h00};
    return {16'(vecOf(k) + 16'd1), 1'b1, 1'b0, 8'h00};
  endfunction

  // starts at the negedge after the sequencer entered its first bus step
  task automatic checkSeq(input int k, input logic [15:0] pcRaw, input logic [7:0] sp,
                          input logic [7:0] st);
    logic [15:0] pc, vb;
    string t;
    pc = (k == KBRK) ? pcRaw + 16'd1 : pcRaw;
    t  = (k == KRST) ? "R6" : ((k == KBRK) ? "R4" : "R3");
    for (int i = (k == KBRK) ? 2 : 0; i < 7; i++) begin
      check((i < 2) ? "R2" : ((i > 4) ? "R5" : t),
            64'({busAddr, busRead, busWrite, busWrite ? busWdata : 8'h00}),
            64'(expStep(k, i, pc, sp, st)));
      @(negedge clk);
    end
    vb = vecOf(k);
    check("R7 done pulse", 64'(entryDone), 64'd1);
    check("R5 new pc", 64'(newPc), 64'({memByte(vb + 16'd1), memByte(vb)}));
    check("R3 new sp", 64'(newSp), 64'(8'(sp - 8'd3)));
    check("R7 new status", 64'(newStatus), 64'((st | 8'h04) & 8'hF7));
    @(negedge clk);
    check("R7 single pulse", 64'(entryDone), 64'd0);
  endtask

  task automatic setCore(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
    pcIn = pc; spIn = sp; statusIn = st;
  endtask

  task automatic boundaryEntry(input int k, input logic [15:0] pc, input logic [7:0] sp,
                               input logic [7:0] st);
    setCore(pc, sp, st);
    if (k == KBRK) brkCmd = 1; else atBoundary = 1;
    if (k == KRST) rstReq = 1;
    if (k == KIRQ) irqReq = 1;
    @(negedge clk);
    brkCmd = 0; atBoundary = 0; rstReq = 0; irqReq = 0;
    checkSeq(k, pc, sp, st);
  endtask

  task automatic noEntry(input string tag);
    atBoundary = 1;
    @(negedge clk);
    atBoundary = 0;
    check(tag, 64'({active, busRead, busWrite}), 64'd0);
    @(negedge clk);
  endtask

  task automatic nmiPulse();
    nmiN = 0; @(negedge clk); nmiN = 1; @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R10 idle after reset",
          64'({busRead, busWrite, entryDone, waiting, stopped, active}), 64'd0);

    // power-on pending from reset, taken at first boundary
    boundaryEntry(KRST, 16'h8000, 8'hFD, 8'h28);
    noEntry("R8 power-on cleared after take");

    // masked maskable request
    setCore(16'h2000, 8'hF0, 8'h04);
    irqReq = 1;
    noEntry("R1 irq masked");
    irqReq = 0;
    boundaryEntry(KIRQ, 16'h2000, 8'hF0, 8'h08);

    // NMI beats IRQ; IRQ follows
    nmiPulse();
    irqReq = 1;
    boundaryEntry(KNMI, 16'h3456, 8'h80, 8'hFB);
    boundaryEntry(KIRQ, 16'h3456, 8'h80, 8'h00);

    // reset beats pending NMI; NMI kept until taken
    nmiPulse();
    boundaryEntry(KRST, 16'h4000, 8'h02, 8'h00);
    boundaryEntry(KNMI, 16'h4001, 8'h01, 8'h10);
    noEntry("R8 nmi cleared when taken");

    // NMI edge in the same cycle the pending NMI is taken
    nmiPulse();
    setCore(16'h5555, 8'h40, 8'h00);
    atBoundary = 1; nmiN = 0;
    @(negedge clk);
    atBoundary = 0;
    checkSeq(KNMI, 16'h5555, 8'h40, 8'h00);
    nmiN = 1;
    boundaryEntry(KNMI, 16'h6000, 8'h20, 8'h00);
    noEntry("R8 no third nmi");

    // break, including stack wrap
    boundaryEntry(KBRK, 16'hFFFF, 8'h01, 8'h0C);

    // wait released by unmasked irq
    setCore(16'h7000, 8'h90, 8'h00);
    waiCmd = 1; @(negedge clk); waiCmd = 0;
    repeat (3) @(negedge clk);
    check("R9 waiting", 64'({waiting, busRead, busWrite}), 64'h4);
    irqReq = 1; @(negedge clk); irqReq = 0;
    checkSeq(KIRQ, 16'h7000, 8'h90, 8'h00);

    // stop ignores irq and nmi; reset releases
    setCore(16'h7100, 8'h70, 8'h00);
    stpCmd = 1; @(negedge clk); stpCmd = 0;
    irqReq = 1; nmiPulse(); repeat (3) @(negedge clk);
    check("R9 stop holds", 64'({stopped, busRead, busWrite}), 64'h4);
    irqReq = 0;
    rstReq = 1; @(negedge clk); rstReq = 0;
    checkSeq(KRST, 16'h7100, 8'h70, 8'h00);
    boundaryEntry(KNMI, 16'h7200, 8'h6D, 8'h00);

    // randomized mix
    for (int n = 0; n < 40; n++) begin
      int k;
      logic [15:0] pc;
      logic [7:0] sp, st;
      k  = int'($urandom_range(0, 3));
      pc = 16'($urandom);
      sp = 8'($urandom);
      st = 8'($urandom);
      if (k == KIRQ) st[2] = 1'b0;
      if (k == KNMI) nmiPulse();
      boundaryEntry(k, pc, sp, st);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule